// File: doc/BRIEF.md
# Multi-Channel Serial Level Link

This block carries a group of slow, independent logic levels across one serial bit line. A transmitter synchronises every channel input and takes a snapshot of all of them once per frame period. It then shifts the snapshot out as a short self-framing packet. The bit clock is far faster than the input levels can change, so a level held for the minimum pulse width always shows up in at least one packet.

The receiver watches the line for the start pattern and collects the channel bits and the check bit. It loads its output word only from a packet whose check bit is correct, so a damaged packet leaves the previous levels on the outputs. A link-good flag rises after a run of consecutive good packets. It falls when the line goes quiet for longer than one frame plus a fixed margin. Both halves start working by themselves after reset and need no setup.

A packet is the start pattern `110`, then one bit per channel with channel 0 first, then an even-parity bit over the channel bits. It is `N+4` bits long. The line rests at 0 between packets. With the default of six channels and a ten-cycle frame, packets follow each other with no gap.

Top module: `chanlink_top`

## Requirements
- R1: `line_out` sends one packet per `PERIOD` cycles. Each packet is, in order: 1, 1, 0, `chan_in[0]` through `chan_in[N-1]`, and then the even parity of those N bits. `line_out` is 0 whenever no packet bit is being sent.
- R2: When all inputs change together and then hold, `chan_out` takes the new word within `PERIOD+N+8` cycles. It never shows a word that mixes old and new channel values.
- R3: A packet whose parity bit does not make the count of ones over channel and parity bits even is dropped. `chan_out` keeps its previous value.
- R4: A bit sequence that lacks the `110` start pattern is never taken as a packet, and `chan_out` keeps its value.
- R5: `link_ok` rises with the fourth consecutive good packet and not earlier.
- R6: A packet with a parity error restarts the count of consecutive good packets.
- R7: `link_ok` falls once `PERIOD+8` cycles pass with no good packet. `chan_out` keeps its last value.
- R8: In reset, `chan_out`, `link_ok` and `line_out` are all 0. With `line_out` looped back to `line_in`, `link_ok` rises within `6*PERIOD+10` cycles of reset release, with no other setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by transmitter and receiver |
| rst | input | 1 | Synchronous active-high reset |
| chan_in | input | N | Asynchronous channel levels to transmit |
| line_out | output | 1 | Serial packet stream from the transmitter |
| line_in | input | 1 | Serial stream into the receiver |
| chan_out | output | N | Channel levels from the last good packet |
| link_ok | output | 1 | Link-good flag |

## Verification
The hardest condition to reach from the ports is a receiver that sees a damaged or misframed packet while the transmitter keeps producing clean ones. In loopback the line is always correct. So the bench takes over `line_in` and builds its own packets bit by bit. These include packets with an inverted parity bit, a frame with a false start pattern, and quiet gaps timed to the cycle. The bench then measures the exact cycle at which `link_ok` rises and falls.

// File: rtl/chanlink_pkg.sv
package chanlink_pkg;

  localparam int START_W = 3;
  localparam logic [START_W-1:0] START_PAT = 3'b110;

  typedef enum logic [0:0] {
    RX_HUNT,
    RX_BODY
  } rx_state_e;

  // start pattern + one bit per channel + parity
  function automatic int frame_len(input int n_ch);
    return START_W + n_ch + 1;
  endfunction

endpackage

// File: rtl/chanlink_sync.sv
module chanlink_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/chanlink_tx.sv
module chanlink_tx
  import chanlink_pkg::*;
#(
  parameter int N      = 6,
  parameter int PERIOD = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic         line_out
);

  localparam int LEN = frame_len(N);
  localparam int CW  = $clog2(PERIOD);

  logic [CW-1:0]  cnt;
  logic [LEN-1:0] frame;
  logic [LEN-1:0] shreg;

  always_comb begin
    frame = '0;
    frame[LEN-1 -: START_W] = START_PAT;
    for (int i = 0; i < N; i++) frame[LEN-1-START_W-i] = d[i];
    frame[0] = ^d;
  end

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (cnt == CW'(PERIOD - 1))  cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  // load at frame slot 0, otherwise shift out MSB first with 0 fill
  always_ff @(posedge clk) begin
    if (rst)             shreg <= '0;
    else if (cnt == '0)  shreg <= frame;
    else                 shreg <= {shreg[LEN-2:0], 1'b0};
  end

  assign line_out = shreg[LEN-1];

  a_r1_lead_bit_high: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(1)) |-> line_out);

  a_r1_third_start_low: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(3)) |-> !line_out);

endmodule

// File: rtl/chanlink_rx.sv
module chanlink_rx
  import chanlink_pkg::*;
#(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         line_in,
  output logic [N-1:0] data_out,
  output logic         good_q,
  output logic         bad_q
);

  localparam int BW = N + 1;
  localparam int DW = $clog2(BW + 1);

  rx_state_e      state;
  logic [1:0]     hreg;
  logic [DW-1:0]  dcnt;
  logic [BW-1:0]  body;
  logic [BW-1:0]  full;
  logic [N-1:0]   unpacked;

  assign full = {body[N-1:0], line_in};

  always_comb begin
    for (int i = 0; i < N; i++) unpacked[i] = full[N-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_HUNT;
      hreg     <= '0;
      dcnt     <= '0;
      body     <= '0;
      data_out <= '0;
      good_q   <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      good_q <= 1'b0;
      bad_q  <= 1'b0;
      case (state)
        RX_HUNT: begin
          if ({hreg, line_in} == START_PAT) begin
            state <= RX_BODY;
            dcnt  <= '0;
            hreg  <= '0;
          end else begin
            hreg <= {hreg[0], line_in};
          end
        end
        RX_BODY: begin
          body <= {body[BW-2:0], line_in};
          dcnt <= dcnt + 1'b1;
          if (dcnt == DW'(N)) begin
            state <= RX_HUNT;
            dcnt  <= '0;
            if (^full == 1'b0) begin
              data_out <= unpacked;
              good_q   <= 1'b1;
            end else begin
              bad_q <= 1'b1;
            end
          end
        end
        default: state <= RX_HUNT;
      endcase
    end
  end

  a_r2_change_only_on_good: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_out) |-> good_q);

  a_r3_hold_on_bad: assert property (@(posedge clk) disable iff (rst)
    bad_q |-> $stable(data_out));

endmodule

// File: rtl/chanlink_mon.sv
module chanlink_mon #(
  parameter int PERIOD = 10,
  parameter int RUN    = 4,
  parameter int SLACK  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic good,
  input  logic bad,
  output logic link_ok
);

  localparam int TIMEOUT = PERIOD + SLACK;
  localparam int RW      = $clog2(RUN + 1);
  localparam int SW      = $clog2(TIMEOUT + 1);

  logic [RW-1:0] run;
  logic [SW-1:0] sil;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= '0;
      sil     <= '0;
      link_ok <= 1'b0;
    end else if (good) begin
      sil <= '0;
      if (run != RW'(RUN))     run     <= run + 1'b1;
      if (run == RW'(RUN - 1)) link_ok <= 1'b1;
    end else begin
      if (bad) run <= '0;
      if (sil == SW'(TIMEOUT - 1)) begin
        link_ok <= 1'b0;
        run     <= '0;
      end else begin
        sil <= sil + 1'b1;
      end
    end
  end

  a_r5_rise_on_good: assert property (@(posedge clk) disable iff (rst)
    $rose(link_ok) |-> $past(good));

  a_r7_fall_not_on_good: assert property (@(posedge clk) disable iff (rst)
    $fell(link_ok) |-> !$past(good));

  a_r6_bad_blocks_rise: assert property (@(posedge clk) disable iff (rst)
    (bad && !link_ok) |=> !link_ok);

endmodule

// File: rtl/chanlink_top.sv
module chanlink_top #(
  parameter int N      = 6,
  parameter int PERIOD = 10,
  parameter int SYNC   = 2,
  parameter int RUN    = 4,
  parameter int SLACK  = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] chan_in,
  output logic         line_out,
  input  logic         line_in,
  output logic [N-1:0] chan_out,
  output logic         link_ok
);

  logic [N-1:0] chan_sync;
  logic         pkt_good;
  logic         pkt_bad;

  chanlink_sync #(.W(N), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (chan_in),
    .q   (chan_sync)
  );

  chanlink_tx #(.N(N), .PERIOD(PERIOD)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .d        (chan_sync),
    .line_out (line_out)
  );

  chanlink_rx #(.N(N)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .line_in  (line_in),
    .data_out (chan_out),
    .good_q   (pkt_good),
    .bad_q    (pkt_bad)
  );

  chanlink_mon #(.PERIOD(PERIOD), .RUN(RUN), .SLACK(SLACK)) u_mon (
    .clk     (clk),
    .rst     (rst),
    .good    (pkt_good),
    .bad     (pkt_bad),
    .link_ok (link_ok)
  );

endmodule

// File: tb/chanlink_top_bench.sv
module chanlink_top_bench;

  localparam int N      = 6;
  localparam int PER    = 10;
  localparam int LEN    = N + 4;
  localparam int TMO    = PER + 8;
  localparam int LATMAX = PER + N + 8;
  localparam int NVEC   = 8;
  localparam logic [N-1:0] VEC [NVEC] = '{6'h2A, 6'h15, 6'h3F, 6'h00,
                                         6'h01, 6'h20, 6'h33, 6'h0C};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] chan_in = '0;
  logic         line_out_w;
  logic         line_in_w;
  logic [N-1:0] chan_out;
  logic         link_ok;
  logic         use_bench = 1'b0;
  logic         bench_bit = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign line_in_w = use_bench ? bench_bit : line_out_w;

  chanlink_top u_chanlink_top (
    .clk      (clk),
    .rst      (rst),
    .chan_in  (chan_in),
    .line_out (line_out_w),
    .line_in  (line_in_w),
    .chan_out (chan_out),
    .link_ok  (link_ok)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [LEN-1:0] mk_frame(input logic [N-1:0] v, input bit flip, input bit bad_start);
    logic [LEN-1:0] f;
    f[LEN-1 -: 3] = bad_start ? 3'b100 : 3'b110;
    for (int i = 0; i < N; i++) f[LEN-4-i] = v[i];
    f[0] = (^v) ^ flip;
    return f;
  endfunction

  task automatic send_raw(input logic [LEN-1:0] f);
    for (int b = LEN - 1; b >= 0; b--) begin
      @(negedge clk) bench_bit = f[b];
      @(posedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) bench_bit = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic good_pkt(input logic [N-1:0] v);
    send_raw(mk_frame(v, 1'b0, 1'b0));
    idle(3);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] cap;
    logic [N-1:0]   old_v;
    bit             found;
    int             rel;
    int             lat;

    // R8: reset state
    chan_in = 6'h25;
    repeat (4) @(negedge clk);
    chk(chan_out == '0, "R8 reset chan_out", chan_out, 0);
    chk(link_ok == 1'b0, "R8 reset link_ok", link_ok, 0);
    chk(line_out_w == 1'b0, "R8 reset line_out", line_out_w, 0);
    rst = 1'b0;
    rel = cyc;

    // R1: capture third packet on line_out
    found = 0;
    for (int k = 0; k < 30 && !found; k++) begin
      @(negedge clk);
      if (line_out_w) found = 1;
    end
    chk(found, "R1 first packet start", found, 1);
    repeat (2 * PER) @(negedge clk);
    cap[LEN-1] = line_out_w;
    for (int b = LEN - 2; b >= 0; b--) begin
      @(negedge clk);
      cap[b] = line_out_w;
    end
    chk(cap == mk_frame(6'h25, 1'b0, 1'b0), "R1 packet bits", cap, mk_frame(6'h25, 1'b0, 1'b0));

    // R8: self-start of the loopback link
    for (int k = 0; k < 80 && !link_ok; k++) @(negedge clk);
    chk(link_ok && (cyc - rel) <= 6 * PER + 10, "R8 self-start", cyc - rel, 6 * PER + 10);
    chk(chan_out == 6'h25, "R8 loopback word", chan_out, 6'h25);

    // R2: vector table walked in loopback
    old_v = 6'h25;
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk) chan_in = VEC[v];
      lat = 0;
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        if (chan_out != old_v && chan_out != VEC[v])
          chk(1'b0, "R2 mixed word", chan_out, VEC[v]);
        if (lat == 0 && chan_out == VEC[v]) lat = k;
      end
      chk(lat != 0 && lat <= LATMAX, "R2 latency", lat, LATMAX);
      chk(chan_out == VEC[v] && link_ok, "R2 word held", chan_out, VEC[v]);
      old_v = VEC[v];
    end

    // R7: quiet line drops the link, outputs hold
    use_bench = 1'b1;
    idle(40);
    @(negedge clk);
    chk(link_ok == 1'b0, "R7 drop after silence", link_ok, 0);
    chk(chan_out == 6'h0C, "R7 hold after silence", chan_out, 6'h0C);

    // R3 / R6: bad parity dropped and run restarted
    good_pkt(6'h11);
    good_pkt(6'h22);
    send_raw(mk_frame(6'h3C, 1'b1, 1'b0));
    idle(3);
    @(negedge clk);
    chk(chan_out == 6'h22, "R3 bad parity held", chan_out, 6'h22);
    good_pkt(6'h05);
    good_pkt(6'h06);
    good_pkt(6'h07);
    @(negedge clk);
    chk(link_ok == 1'b0, "R6 run restarted", link_ok, 0);
    chk(chan_out == 6'h07, "R2 bench packet word", chan_out, 6'h07);
    good_pkt(6'h08);
    @(negedge clk);
    chk(link_ok == 1'b1, "R6 fourth after bad", link_ok, 1);

    // R4: false start pattern ignored (bits 100 + 0x2A + 0 contain no 110)
    send_raw(mk_frame(6'h2A, 1'b1, 1'b1));
    idle(3);
    @(negedge clk);
    chk(chan_out == 6'h08, "R4 false start ignored", chan_out, 6'h08);
    good_pkt(6'h19);
    @(negedge clk);
    chk(chan_out == 6'h19, "R4 next good accepted", chan_out, 6'h19);

    // R7: exact drop window
    good_pkt(6'h01);
    good_pkt(6'h02);
    good_pkt(6'h03);
    send_raw(mk_frame(6'h04, 1'b0, 1'b0));
    idle(17);
    @(negedge clk);
    chk(link_ok == 1'b1, "R7 still up before timeout", link_ok, 1);
    idle(4);
    @(negedge clk);
    chk(link_ok == 1'b0, "R7 down after timeout", link_ok, 0);
    chk(chan_out == 6'h04, "R7 word kept", chan_out, 6'h04);

    // R5: needs four consecutive good packets
    good_pkt(6'h31);
    good_pkt(6'h32);
    good_pkt(6'h33);
    @(negedge clk);
    chk(link_ok == 1'b0, "R5 not after three", link_ok, 0);
    good_pkt(6'h34);
    @(negedge clk);
    chk(link_ok == 1'b1, "R5 up after four", link_ok, 1);

    // R8: reset in operation, then self-start again
    @(negedge clk) rst = 1'b1;
    use_bench = 1'b0;
    chan_in = 6'h1E;
    repeat (3) @(negedge clk);
    chk(chan_out == '0 && link_ok == 1'b0, "R8 mid reset outputs", {link_ok, chan_out}, 0);
    chk(line_out_w == 1'b0, "R8 mid reset line", line_out_w, 0);
    rst = 1'b0;
    rel = cyc;
    for (int k = 0; k < 80 && !link_ok; k++) @(negedge clk);
    chk(link_ok && (cyc - rel) <= 6 * PER + 10, "R8 restart", cyc - rel, 6 * PER + 10);
    chk(chan_out == 6'h1E, "R8 restart word", chan_out, 6'h1E);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule